// File: doc/BRIEF.md
# Paper Tape Reader Controller

This block sits between a CPU's I/O pulse decoder and a paper tape reader mechanism. The CPU drives a 3-bit pulse field together with a mode select, and the block answers with a skip indication, a returned data word and a status word. The reader side offers 8-bit frames through a one-cycle valid strobe. It also reports whether tape is loaded and whether the tape has run out.

A start pulse arms one read in one of two formats. In alphanumeric format a single frame completes the read. The frame is stored as is, with even parity rebuilt in the top bit, or with the top bit forced high. In binary format, frames without the top (channel-8) hole are skipped. The low 6 bits of each frame that is kept fill the 18-bit word from the most significant slice down, and the read completes after the third such frame. A missing tape or an out-of-tape condition ends a pending read with both the done and error flags set.

Top module: `tape_rdr_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the buffer, the done flag, the error flag, the read-in-progress state and the format state. After reset, `skip_o`, `rdata_o` and `status_o` read zero, and frames are not accepted until a new start.
- R2: When `pulse_i[0]` is high, `skip_o` in the next cycle equals the done flag as it was when the pulse was sampled. Otherwise `skip_o` is 0.
- R3: When `pulse_i[1]` is high, `rdata_o` in the next cycle is `bus_i` ORed with the 18-bit buffer, and the done flag is cleared. Without this pulse, `rdata_o` is `bus_i`.
- R4: When `pulse_i[2]` is high, the buffer and the done flag are cleared and a read begins. The read is binary if `bin_i` is 1 and alphanumeric otherwise. The error flag is also cleared unless `STATIC_ERR` is 1.
- R5: A frame presented while no read is in progress, or in the same cycle as a start pulse, is ignored. The buffer and the done flag are unchanged.
- R6: An alphanumeric read completes on its first frame. The conditioned 8-bit frame goes to buffer bits 7:0, and bits 17:8 are 0. `par_i` encodes 0 = store unchanged, 1 = even parity, 2 = forced top bit, 3 = store unchanged.
- R7: With `par_i` = 1, buffer bits 6:0 equal frame bits 6:0, and bit 7 is set so that bits 7:0 hold an even number of ones.
- R8: With `par_i` = 2, the stored frame equals the input frame with bit 7 set to 1.
- R9: In a binary read, a frame whose bit 7 is 0 is skipped. Accepted frames place their bits 5:0 into buffer bits 17:12, then 11:6, then 5:0. `par_i` has no effect.
- R10: A binary read sets the done flag on the cycle after its third accepted frame, and not before. Frames after completion are ignored.
- R11: While a read is in progress, `tape_ok_i` = 0 or `tape_end_i` = 1 ends the read and sets both the done and error flags on the next cycle. This takes priority over a frame in the same cycle.
- R12: `status_o` carries the done flag at bit `DONE_BIT` (default 14) and the error flag at bit `ERR_BIT` (default 13). All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 3 | I/O pulse field: bit 0 skip test, bit 1 read buffer, bit 2 start read |
| bin_i | input | 1 | Format select sampled with a start: 1 binary, 0 alphanumeric |
| par_i | input | 2 | Alphanumeric frame conditioning select |
| bus_i | input | 18 | Data bus arriving at the device, ORed into the returned word |
| frame_valid_i | input | 1 | One-cycle strobe for a reader frame |
| frame_i | input | 8 | Reader frame; bit 7 is the binary marker hole |
| tape_ok_i | input | 1 | Tape is loaded |
| tape_end_i | input | 1 | Reader reports out of tape |
| skip_o | output | 1 | Registered skip answer to a skip-test pulse |
| rdata_o | output | 18 | Registered returned data word |
| status_o | output | 18 | Done and error flags at their status positions |

## Verification
On every cycle, the bound checker confirms several invariants. The done flag and read-in-progress are never both set. A start leaves an empty buffer with done low. An idle cycle never alters the buffer. A tape fault during a read closes it with both flags. The skip answer tracks the prior done flag. The packing order, the skipping of unmarked frames, the three parity conditionings and the exact word assembled can only be shown by the bench's vector table, which compares whole reads against hand-computed words. The same holds for the OR with the incoming bus and for a reset during a partial read.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [1:0] {
    PAR_PLAIN = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_FORCE = 2'd2,
    PAR_RSVD  = 2'd3
  } par_mode_e;

  localparam int P_SKIP  = 0;
  localparam int P_READ  = 1;
  localparam int P_START = 2;
  localparam int PULSE_W = 3;
endpackage

// File: rtl/rdr_frame_cond.sv
module rdr_frame_cond
  import rdr_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  par_mode_e          mode_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int LOW_W = FRAME_W - 1;

  logic [LOW_W-1:0] low;
  assign low = frame_i[LOW_W-1:0];

  always_comb begin
    unique case (mode_i)
      PAR_EVEN:  frame_o = {^low, low};
      PAR_FORCE: frame_o = {1'b1, low};
      default:   frame_o = frame_i;
    endcase
  end
endmodule

// File: rtl/rdr_word_pack.sv
module rdr_word_pack #(
  parameter int WORD_W  = 18,
  parameter int FRAME_W = 8,
  parameter int SLICE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_i,
  input  logic               alpha_we_i,
  input  logic               bin_we_i,
  input  logic [FRAME_W-1:0] alpha_i,
  input  logic [SLICE_W-1:0] slice_i,
  output logic               last_slice_o,
  output logic [WORD_W-1:0]  word_o
);
  localparam int SLICES = WORD_W / SLICE_W;
  localparam int SLOT_W = $clog2(SLICES + 1);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLICES - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] word_q;

  assign last_slice_o = (slot_q == LAST);
  assign word_o       = word_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      slot_q <= '0;
      word_q <= '0;
    end else if (alpha_we_i) begin
      word_q <= WORD_W'(alpha_i);
    end else if (bin_we_i) begin
      for (int s = 0; s < SLICES; s++) begin
        if (slot_q == SLOT_W'(s))
          word_q[WORD_W-1-s*SLICE_W -: SLICE_W] <= slice_i;
      end
      slot_q <= last_slice_o ? '0 : slot_q + 1'b1;
    end
  end
endmodule

// File: rtl/rdr_flag_ctl.sv
module rdr_flag_ctl #(
  parameter bit STATIC_ERR = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic start_bin_i,
  input  logic rd_clr_i,
  input  logic fault_i,
  input  logic complete_i,
  output logic busy_o,
  output logic bin_o,
  output logic done_o,
  output logic err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      bin_o  <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      bin_o  <= start_bin_i;
      done_o <= 1'b0;
      if (!STATIC_ERR) err_o <= 1'b0;
    end else if (fault_i) begin
      busy_o <= 1'b0;
      done_o <= 1'b1;
      err_o  <= 1'b1;
    end else if (complete_i) begin
      busy_o <= 1'b0;
      done_o <= 1'b1;
    end else if (rd_clr_i) begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tape_rdr_ctrl.sv
module tape_rdr_ctrl
  import rdr_pkg::*;
#(
  parameter int WORD_W     = 18,
  parameter int FRAME_W    = 8,
  parameter int SLICE_W    = 6,
  parameter int DONE_BIT   = 14,
  parameter int ERR_BIT    = 13,
  parameter bit STATIC_ERR = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         pulse_i,
  input  logic               bin_i,
  input  logic [1:0]         par_i,
  input  logic [WORD_W-1:0]  bus_i,
  input  logic               frame_valid_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tape_ok_i,
  input  logic               tape_end_i,
  output logic               skip_o,
  output logic [WORD_W-1:0]  rdata_o,
  output logic [WORD_W-1:0]  status_o
);
  localparam int MARK_BIT = FRAME_W - 1;

  logic start, rd_clr, fault, accept;
  logic alpha_we, bin_we, complete, last_slice;
  logic busy, bin_mode, done, err;
  logic [FRAME_W-1:0] cond_frame;
  logic [WORD_W-1:0]  word;

  assign start    = pulse_i[P_START];
  assign rd_clr   = pulse_i[P_READ];
  assign fault    = busy && !start && (!tape_ok_i || tape_end_i);
  assign accept   = busy && !start && !fault && frame_valid_i;
  assign alpha_we = accept && !bin_mode;
  assign bin_we   = accept && bin_mode && frame_i[MARK_BIT];
  assign complete = alpha_we || (bin_we && last_slice);

  rdr_frame_cond #(.FRAME_W(FRAME_W)) u_cond (
    .mode_i (par_mode_e'(par_i)),
    .frame_i(frame_i),
    .frame_o(cond_frame)
  );

  rdr_word_pack #(
    .WORD_W(WORD_W), .FRAME_W(FRAME_W), .SLICE_W(SLICE_W)
  ) u_pack (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (start),
    .alpha_we_i  (alpha_we),
    .bin_we_i    (bin_we),
    .alpha_i     (cond_frame),
    .slice_i     (frame_i[SLICE_W-1:0]),
    .last_slice_o(last_slice),
    .word_o      (word)
  );

  rdr_flag_ctl #(.STATIC_ERR(STATIC_ERR)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .start_bin_i(bin_i),
    .rd_clr_i   (rd_clr),
    .fault_i    (fault),
    .complete_i (complete),
    .busy_o     (busy),
    .bin_o      (bin_mode),
    .done_o     (done),
    .err_o      (err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      skip_o  <= pulse_i[P_SKIP] && done;
      rdata_o <= bus_i | (rd_clr ? word : '0);
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[DONE_BIT] = done;
    status_o[ERR_BIT]  = err;
  end
endmodule

// File: rtl/tape_rdr_ctrl_chk.sv
module tape_rdr_ctrl_chk #(
  parameter int WORD_W     = 18,
  parameter bit STATIC_ERR = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        pulse_i,
  input logic              tape_ok_i,
  input logic              tape_end_i,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [WORD_W-1:0] word,
  input logic              skip_o
);
  // R10
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_i[2] |=> busy && !done && (word == '0));

  // R2
  skip_track_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_i[0] |=> skip_o == $past(done));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pulse_i[2]) |=> $stable(word));

  // R11
  fault_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !pulse_i[2] && (!tape_ok_i || tape_end_i)) |=> done && err && !busy);

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_i[1] && !busy && !pulse_i[2]) |=> !done);

  generate
    if (!STATIC_ERR) begin : g_dyn_err
      // R4
      start_err_clr_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_i[2] |=> !err);
    end
  endgenerate
endmodule

bind tape_rdr_ctrl tape_rdr_ctrl_chk #(.WORD_W(WORD_W), .STATIC_ERR(STATIC_ERR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pulse_i   (pulse_i),
  .tape_ok_i (tape_ok_i),
  .tape_end_i(tape_end_i),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .word      (word),
  .skip_o    (skip_o)
);

// File: tb/tape_rdr_ctrl_tb.sv
module tape_rdr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int DB = 14;
  localparam int EB = 13;

  // format, parity, four frames, expected buffer
  localparam logic       V_BIN [N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [1:0] V_PAR [N] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0, 2'd1};
  localparam logic [7:0] V_F0  [N] = '{8'h41, 8'h43, 8'h83, 8'h12, 8'hC1, 8'hBF, 8'h00, 8'h81};
  localparam logic [7:0] V_F1  [N] = '{8'h55, 8'h11, 8'h22, 8'h33, 8'h44, 8'h41, 8'h95, 8'h82};
  localparam logic [7:0] V_F2  [N] = '{8'h66, 8'h11, 8'h22, 8'h33, 8'h44, 8'h81, 8'hAA, 8'h83};
  localparam logic [7:0] V_F3  [N] = '{8'h77, 8'h11, 8'h22, 8'h33, 8'h44, 8'hC2, 8'h80, 8'h84};
  localparam logic [17:0] V_EXP[N] = '{18'h00041, 18'h000C3, 18'h00003, 18'h00092,
                                       18'h000C1, 18'h3F042, 18'h15A80, 18'h01083};

  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  pulse_i = '0;
  logic        bin_i = 0;
  logic [1:0]  par_i = '0;
  logic [17:0] bus_i = '0;
  logic        frame_valid_i = 0;
  logic [7:0]  frame_i = '0;
  logic        tape_ok_i = 1;
  logic        tape_end_i = 0;
  logic        skip_o;
  logic [17:0] rdata_o;
  logic [17:0] status_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_rdr_ctrl u_dut (
    .clk(clk), .rst(rst), .pulse_i(pulse_i), .bin_i(bin_i), .par_i(par_i),
    .bus_i(bus_i), .frame_valid_i(frame_valid_i), .frame_i(frame_i),
    .tape_ok_i(tape_ok_i), .tape_end_i(tape_end_i),
    .skip_o(skip_o), .rdata_o(rdata_o), .status_o(status_o)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a negedge
  task automatic do_pulse(input logic [2:0] p, input logic b);
    pulse_i = p; bin_i = b;
    @(negedge clk);
    pulse_i = '0; bin_i = 0;
  endtask

  task automatic feed(input logic [7:0] f);
    frame_valid_i = 1; frame_i = f;
    @(negedge clk);
    frame_valid_i = 0; frame_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status_o, 18'h0);
    check("R1 skip", {17'h0, skip_o}, 18'h0);
    check("R1 rdata", rdata_o, 18'h0);
    // R2 skip with done low
    do_pulse(3'b001, 0);
    check("R2 skip low", {17'h0, skip_o}, 18'h0);

    // vector table
    for (int e = 0; e < N; e++) begin
      par_i = V_PAR[e];
      do_pulse(3'b100, V_BIN[e]);
      feed(V_F0[e]);
      if (V_BIN[e]) check("R10 not done early", {17'h0, status_o[DB]}, 18'h0);
      feed(V_F1[e]);
      feed(V_F2[e]);
      feed(V_F3[e]);
      check("R6 R10 done set", {17'h0, status_o[DB]}, 18'h1);
      do_pulse(3'b001, 0);
      check("R2 skip high", {17'h0, skip_o}, 18'h1);
      do_pulse(3'b010, 0);
      check("R6 R7 R8 R9 word", rdata_o, V_EXP[e]);
      check("R3 done cleared", {17'h0, status_o[DB]}, 18'h0);
    end
    par_i = '0;

    // R3 OR with incoming bus, R5 idle frame ignored
    do_pulse(3'b100, 0);
    feed(8'h41);
    bus_i = 18'h20000;
    do_pulse(3'b010, 0);
    check("R3 bus or", rdata_o, 18'h20041);
    bus_i = '0;
    feed(8'h7E);
    check("R5 idle done", {17'h0, status_o[DB]}, 18'h0);
    do_pulse(3'b010, 0);
    check("R5 idle buffer", rdata_o, 18'h00041);

    // R4 start clears buffer
    do_pulse(3'b100, 0);
    do_pulse(3'b010, 0);
    check("R4 buffer cleared", rdata_o, 18'h0);
    feed(8'h05);

    // R11 no tape
    tape_ok_i = 0;
    do_pulse(3'b100, 0);
    @(negedge clk);
    check("R11 no tape", status_o, 18'h0 | (18'h1 << DB) | (18'h1 << EB));
    check("R12 status err", {17'h0, status_o[EB]}, 18'h1);
    tape_ok_i = 1;
    do_pulse(3'b100, 1);
    check("R4 err cleared", {17'h0, status_o[EB]}, 18'h0);
    feed(8'h81);
    tape_end_i = 1;
    frame_valid_i = 1; frame_i = 8'h82;
    @(negedge clk);
    frame_valid_i = 0; tape_end_i = 0;
    check("R11 out of tape", status_o, (18'h1 << DB) | (18'h1 << EB));
    do_pulse(3'b010, 0);
    check("R11 frame lost", rdata_o, 18'h01000);

    // R1 reset mid-read
    do_pulse(3'b100, 1);
    feed(8'h83);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 status after reset", status_o, 18'h0);
    feed(8'h41);
    check("R1 no read after reset", {17'h0, status_o[DB]}, 18'h0);
    do_pulse(3'b010, 0);
    check("R1 buffer after reset", rdata_o, 18'h0);

    // R5 frame with start same cycle dropped
    frame_valid_i = 1; frame_i = 8'h33;
    do_pulse(3'b100, 0);
    frame_valid_i = 0;
    check("R5 start frame dropped", {17'h0, status_o[DB]}, 18'h0);
    feed(8'h22);
    do_pulse(3'b010, 0);
    check("R5 second frame kept", rdata_o, 18'h00022);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule